// File: doc/BRIEF.md
# Variable-Pulse-Width Serial Bus Receive Decoder

This block decodes a single-wire variable-pulse-width serial bus. The bus alternates between an active (dominant, input high) and a passive (input low) level. The block measures how long each level lasts, counting in microsecond ticks. It classifies every completed segment, and every segment that has run for too long, as one of these:

- a data bit,
- a start-of-frame,
- an end-of-data,
- an idle bus,
- a break,
- an invalid symbol.

Data bits between start-of-frame and end-of-data are shifted into bytes. Each byte is presented with a one-cycle strobe. At end of data, an 8-bit CRC residue check gives a pass or fail verdict for the frame.

The host can ask the block to ignore the rest of the frame now on the bus. While that request is pending, bytes are withheld until the bus goes idle, but symbol and CRC reports continue. A speed-up input makes every timing window four times shorter, for production and diagnostic traffic.

The input must already be a clean logic level from an analog transceiver. The block synchronises that level internally.

Top module: `vpw_rx_decoder`

## Requirements
- R1: A segment is a data bit when its width is at least 34 and below 163 ticks. A short width (34 to 95) gives bit value 1 when active and 0 when passive. A long width (96 to 162) gives 0 when active and 1 when passive. Bits count only between start-of-frame and end-of-data.
- R2: Bits are shifted in MSB first. After every eighth bit of a frame, `byte_valid` pulses for one cycle with the byte on `byte_data`.
- R3: An active segment that ends with a width from 163 to 239 ticks reports `sym_code` 1 (start-of-frame). It opens a frame and clears the bit count and the CRC.
- R4: A passive level that reaches 163 ticks inside a frame reports `sym_code` 2 (end-of-data) and closes the frame. In the same cycle, `crc_done` pulses.
- R5: `crc_ok` is 1 only when the frame ended on a byte boundary and its CRC residue equals 0xC4. The CRC uses polynomial 0x1D and initial value 0xFF, and is run MSB first over every bit, including the transmitted CRC byte.
- R6: A passive level that reaches 281 ticks reports `sym_code` 3 (idle). `bus_idle` is then high until the next level change.
- R7: An active level that reaches 240 ticks reports `sym_code` 4 (break) and closes any open frame.
- R8: A segment shorter than 34 ticks reports `sym_code` 5 (invalid symbol) and closes any open frame.
- R9: A one-cycle `wfi_req` withholds every `byte_valid` until the next idle report. Symbol and CRC reports are not withheld.
- R10: With `fast_mode` high, a tick lasts a quarter of a microsecond, so every window above is four times shorter in time.
- R11: After reset, all strobes, `sym_code`, `crc_ok` and `bus_idle` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Bus level, 1 = active, asynchronous |
| fast_mode | input | 1 | Quarter-length timing windows |
| wfi_req | input | 1 | One-cycle request to withhold bytes until idle |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| sym_valid | output | 1 | One-cycle strobe for a framing or error symbol |
| sym_code | output | 3 | 1 SOF, 2 EOD, 3 idle, 4 break, 5 invalid |
| crc_done | output | 1 | One-cycle strobe with the CRC verdict |
| crc_ok | output | 1 | CRC verdict, held until the next `crc_done` |
| bus_idle | output | 1 | Bus currently idle |

## Verification
The bench drives several kinds of frame and compares every reported byte, symbol and CRC verdict against a queue.

- Bytes mixing short and long bits at both levels show that active and passive bit values are not swapped.
- A corrupted CRC byte and a four-bit frame separate the residue test from the byte-boundary test.
- A short noise segment and a long active segment inside frames check that the frame closes without a false end-of-data.
- A withhold request in mid-frame, followed by a clean frame, checks both the suppression and its release at idle.
- A frame sent at quarter timing checks that the window boundaries scale with the speed-up input.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SYM_NONE    = 3'd0,
    SYM_SOF     = 3'd1,
    SYM_EOD     = 3'd2,
    SYM_IDLE    = 3'd3,
    SYM_BREAK   = 3'd4,
    SYM_INVALID = 3'd5
  } vpw_sym_e;

  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_GOOD = 8'hC4;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[7] ^ b;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/vpw_tick_gen.sv
module vpw_tick_gen #(
  parameter int CLKS_PER_US = 16,
  parameter int FAST_DIV    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic tick
);
  localparam int DIV_W    = $clog2(CLKS_PER_US + 1);
  localparam int FAST_LIM = CLKS_PER_US / FAST_DIV;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = fast ? DIV_W'(FAST_LIM - 1) : DIV_W'(CLKS_PER_US - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R10: the fast divisor must leave at least one clock per tick
  initial assert_fast_div_R10: assert (FAST_LIM >= 1 && FAST_LIM * FAST_DIV == CLKS_PER_US);
endmodule

// File: rtl/vpw_width_meter.sv
module vpw_width_meter #(
  parameter int CNT_W    = 9,
  parameter int EOD_US   = 163,
  parameter int IDLE_US  = 281,
  parameter int BREAK_US = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bus_in,
  output logic             level,
  output logic             seg_done,
  output logic             seg_level,
  output logic [CNT_W-1:0] seg_width,
  output logic             cross_eod,
  output logic             cross_idle,
  output logic             cross_break
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] EOD_AT   = CNT_W'(EOD_US - 1);
  localparam logic [CNT_W-1:0] IDLE_AT  = CNT_W'(IDLE_US - 1);
  localparam logic [CNT_W-1:0] BREAK_AT = CNT_W'(BREAK_US - 1);

  logic             sync1, sync2;
  logic [CNT_W-1:0] cnt;
  logic             chg;
  logic             grow;

  assign chg  = sync2 != level;
  assign grow = tick && !chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1       <= 1'b0;
      sync2       <= 1'b0;
      level       <= 1'b0;
      cnt         <= '0;
      seg_done    <= 1'b0;
      seg_level   <= 1'b0;
      seg_width   <= '0;
      cross_eod   <= 1'b0;
      cross_idle  <= 1'b0;
      cross_break <= 1'b0;
    end else begin
      sync1       <= bus_in;
      sync2       <= sync1;
      level       <= sync2;
      seg_done    <= chg;
      cross_eod   <= grow && !level && cnt == EOD_AT;
      cross_idle  <= grow && !level && cnt == IDLE_AT;
      cross_break <= grow &&  level && cnt == BREAK_AT;
      if (chg) begin
        seg_level <= level;
        seg_width <= cnt;
        cnt       <= '0;
      end else if (tick && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: a finished segment is always followed by the opposite level
  assert_seg_alternates_R1: assert property (@(posedge clk) disable iff (rst)
    seg_done |-> seg_level != level);
  // R6: idle can only be reached while the bus is passive
  assert_idle_on_passive_R6: assert property (@(posedge clk) disable iff (rst)
    cross_idle |-> !level);
endmodule

// File: rtl/vpw_rx_decoder.sv
module vpw_rx_decoder
  import vpw_rx_pkg::*;
#(
  parameter int CLKS_PER_US = 16,
  parameter int CNT_W       = 9,
  parameter int MIN_US      = 34,
  parameter int LONG_US     = 96,
  parameter int SOF_US      = 163,
  parameter int BREAK_US    = 240,
  parameter int IDLE_US     = 281
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_in,
  input  logic              fast_mode,
  input  logic              wfi_req,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              sym_valid,
  output logic [2:0]        sym_code,
  output logic              crc_done,
  output logic              crc_ok,
  output logic              bus_idle
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] W_MIN   = CNT_W'(MIN_US);
  localparam logic [CNT_W-1:0] W_LONG  = CNT_W'(LONG_US);
  localparam logic [CNT_W-1:0] W_SOF   = CNT_W'(SOF_US);
  localparam logic [CNT_W-1:0] W_BREAK = CNT_W'(BREAK_US);

  logic             tick, level;
  logic             seg_done, seg_level;
  logic [CNT_W-1:0] seg_width;
  logic             cross_eod, cross_idle, cross_break;

  vpw_tick_gen #(.CLKS_PER_US(CLKS_PER_US), .FAST_DIV(4)) u_tick (
    .clk(clk), .rst(rst), .fast(fast_mode), .tick(tick)
  );

  vpw_width_meter #(
    .CNT_W(CNT_W), .EOD_US(SOF_US), .IDLE_US(IDLE_US), .BREAK_US(BREAK_US)
  ) u_meter (
    .clk(clk), .rst(rst), .tick(tick), .bus_in(bus_in), .level(level),
    .seg_done(seg_done), .seg_level(seg_level), .seg_width(seg_width),
    .cross_eod(cross_eod), .cross_idle(cross_idle), .cross_break(cross_break)
  );

  // symbol classification of the segment that just ended
  logic receiving;
  logic is_short, is_long, is_sof;
  logic bit_evt, bit_val, sof_evt, inv_evt, eod_evt;

  always_comb begin
    is_short = seg_width >= W_MIN  && seg_width < W_LONG;
    is_long  = seg_width >= W_LONG && seg_width < W_SOF;
    is_sof   = seg_width >= W_SOF  && seg_width < W_BREAK;
    inv_evt  = seg_done && seg_width < W_MIN;
    bit_evt  = seg_done && receiving && (is_short || is_long);
    bit_val  = seg_level ? is_short : is_long;
    sof_evt  = seg_done && seg_level && is_sof;
    eod_evt  = cross_eod && receiving;
  end

  // frame assembly, CRC and reporting
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [7:0]        crc;
  logic              suppress;

  always_ff @(posedge clk) begin
    if (rst) begin
      receiving  <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      crc        <= CRC_INIT;
      suppress   <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      sym_valid  <= 1'b0;
      sym_code   <= SYM_NONE;
      crc_done   <= 1'b0;
      crc_ok     <= 1'b0;
      bus_idle   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      sym_valid  <= 1'b0;
      crc_done   <= 1'b0;

      if (wfi_req)         suppress <= 1'b1;
      else if (cross_idle) suppress <= 1'b0;

      if (cross_idle)    bus_idle <= 1'b1;
      else if (seg_done) bus_idle <= 1'b0;

      if (sof_evt) begin
        receiving <= 1'b1;
        bit_cnt   <= '0;
        crc       <= CRC_INIT;
        sym_valid <= 1'b1;
        sym_code  <= SYM_SOF;
      end else if (bit_evt) begin
        shreg   <= {shreg[BYTE_W-2:0], bit_val};
        crc     <= crc_step(crc, bit_val);
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
          byte_valid <= !suppress;
          byte_data  <= {shreg[BYTE_W-2:0], bit_val};
        end
      end else if (eod_evt) begin
        receiving <= 1'b0;
        sym_valid <= 1'b1;
        sym_code  <= SYM_EOD;
        crc_done  <= 1'b1;
        crc_ok    <= (crc == CRC_GOOD) && (bit_cnt == '0);
      end else if (cross_break) begin
        receiving <= 1'b0;
        sym_valid <= 1'b1;
        sym_code  <= SYM_BREAK;
      end else if (inv_evt) begin
        receiving <= 1'b0;
        sym_valid <= 1'b1;
        sym_code  <= SYM_INVALID;
      end else if (cross_idle) begin
        receiving <= 1'b0;
        sym_valid <= 1'b1;
        sym_code  <= SYM_IDLE;
      end
    end
  end

  // R4: a CRC verdict only comes with an end-of-data report
  assert_crc_with_eod_R4: assert property (@(posedge clk) disable iff (rst)
    crc_done |-> sym_valid && sym_code == SYM_EOD);
  // R6: the idle flag rises together with the idle report
  assert_idle_reported_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_idle) |-> sym_valid && sym_code == SYM_IDLE);
  // R9: no byte is delivered while the withhold request is pending
  assert_no_byte_withheld_R9: assert property (@(posedge clk) disable iff (rst)
    suppress |=> !byte_valid);
  // R2: bytes and symbols never share a strobe cycle
  assert_single_report_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid, sym_valid}));
  // R7: a break always leaves the frame closed
  assert_break_closes_R7: assert property (@(posedge clk) disable iff (rst)
    cross_break |=> !receiving);
endmodule

// File: tb/vpw_rx_decoder_tb.sv
module vpw_rx_decoder_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int CLKS_PER_US = 4;
  localparam int WATCHDOG    = 190000;

  localparam int K_BYTE = 0;
  localparam int K_SYM  = 1;
  localparam int K_CRC  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_in = 1'b0;
  logic       fast_mode = 1'b0;
  logic       wfi_req = 1'b0;
  logic       byte_valid, sym_valid, crc_done, crc_ok, bus_idle;
  logic [7:0] byte_data;
  logic [2:0] sym_code;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vpw_rx_decoder #(.CLKS_PER_US(CLKS_PER_US)) u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .fast_mode(fast_mode), .wfi_req(wfi_req),
    .byte_valid(byte_valid), .byte_data(byte_data), .sym_valid(sym_valid),
    .sym_code(sym_code), .crc_done(crc_done), .crc_ok(crc_ok), .bus_idle(bus_idle)
  );

  typedef struct {
    int    kind;
    int    val;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;
  logic lvl      = 1'b0;

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind;
    e.val  = val;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind, input int val);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL unexpected report: actual kind %0d value %0d expected none", kind, val);
    end else begin
      e = exp_q.pop_front();
      check({e.req, " kind"}, kind, e.kind);
      check({e.req, " value"}, val, e.val);
    end
  endtask

  // monitor: compares each report against the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (sym_valid)  observe(K_SYM, int'(sym_code));
      if (byte_valid) observe(K_BYTE, int'(byte_data));
      if (crc_done)   observe(K_CRC, int'(crc_ok));
    end
  end

  // drive one segment of the given level for a nominal number of microseconds
  task automatic seg(input logic lv, input int us);
    bus_in = lv;
    lvl    = lv;
    repeat (fast_mode ? us * CLKS_PER_US / 4 : us * CLKS_PER_US) @(negedge clk);
  endtask

  // R1 encoding: active short = 1, active long = 0, passive short = 0, passive long = 1
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      logic bv, nl;
      bv = b[7 - i];
      nl = !lvl;
      seg(nl, (nl ? bv : !bv) ? 64 : 128);
    end
  endtask

  function automatic logic [7:0] calc_crc(input logic [7:0] d[$]);
    logic [7:0] c;
    c = 8'hFF;
    foreach (d[k]) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = c[7] ^ d[k][i];
        c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
    end
    return ~c;
  endfunction

  task automatic send_frame(input logic [7:0] d[$], input logic good);
    logic [7:0] c;
    c = calc_crc(d) ^ (good ? 8'h00 : 8'h5A);
    push(K_SYM, 1, "R3 sof");
    seg(1'b1, 200);
    foreach (d[k]) begin
      push(K_BYTE, int'(d[k]), "R1 R2 byte");
      send_bits(d[k], 8);
    end
    push(K_BYTE, int'(c), "R2 crc byte");
    send_bits(c, 8);
    push(K_SYM, 2, "R4 eod");
    push(K_CRC, good ? 1 : 0, "R5 crc verdict");
    push(K_SYM, 3, "R6 idle");
    seg(1'b0, 300);
  endtask

  initial begin
    logic [7:0] fa[$];
    logic [7:0] c;

    repeat (4) @(negedge clk);
    check("R11 reset byte_valid", byte_valid, 0);
    check("R11 reset sym_valid", sym_valid, 0);
    check("R11 reset sym_code", sym_code, 0);
    check("R11 reset crc_done", crc_done, 0);
    check("R11 reset crc_ok", crc_ok, 0);
    check("R11 reset bus_idle", bus_idle, 0);
    rst = 1'b0;

    // bus starts idle
    push(K_SYM, 3, "R6 first idle");
    seg(1'b0, 300);
    check("R6 bus_idle after idle", bus_idle, 1);

    // good frame
    fa = '{8'h68, 8'h6A, 8'hF1};
    send_frame(fa, 1'b1);

    // corrupted CRC
    fa = '{8'hA5, 8'h0F};
    send_frame(fa, 1'b0);

    // four-bit frame: residue irrelevant, not byte aligned
    push(K_SYM, 1, "R3 sof short frame");
    seg(1'b1, 200);
    check("R6 bus_idle low in frame", bus_idle, 0);
    send_bits(8'hA0, 4);
    push(K_SYM, 2, "R4 eod short frame");
    push(K_CRC, 0, "R5 misaligned frame");
    push(K_SYM, 3, "R6 idle short frame");
    seg(1'b0, 300);

    // withhold request mid-frame
    fa = '{8'h11, 8'h22, 8'h33};
    c = calc_crc(fa);
    push(K_SYM, 1, "R9 sof");
    seg(1'b1, 200);
    push(K_BYTE, 8'h11, "R9 byte before request");
    send_bits(8'h11, 8);
    send_bits(8'h22, 1);
    wfi_req = 1'b1;
    @(negedge clk);
    wfi_req = 1'b0;
    send_bits(8'h44, 7);
    send_bits(8'h33, 8);
    send_bits(c, 8);
    push(K_SYM, 2, "R9 eod still reported");
    push(K_CRC, 1, "R9 crc still reported");
    push(K_SYM, 3, "R9 idle releases");
    seg(1'b0, 300);
    fa = '{8'h3C, 8'hC3};
    send_frame(fa, 1'b1);

    // noise inside a frame
    push(K_SYM, 1, "R8 sof");
    seg(1'b1, 200);
    push(K_BYTE, 8'h5A, "R8 byte");
    send_bits(8'h5A, 8);
    push(K_SYM, 5, "R8 invalid");
    seg(1'b0, 20);
    seg(1'b1, 64);
    push(K_SYM, 3, "R8 idle without eod");
    seg(1'b0, 300);

    // break inside a frame
    push(K_SYM, 1, "R7 sof");
    seg(1'b1, 200);
    push(K_BYTE, 8'h96, "R7 byte");
    send_bits(8'h96, 8);
    seg(1'b0, 64);
    push(K_SYM, 4, "R7 break");
    seg(1'b1, 300);
    push(K_SYM, 3, "R7 idle without eod");
    seg(1'b0, 300);

    // quarter timing
    fast_mode = 1'b1;
    @(negedge clk);
    fa = '{8'hC3, 8'h81};
    send_frame(fa, 1'b1);
    fast_mode = 1'b0;

    repeat (20) @(negedge clk);
    check("R2 R6 all expected reports seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule